// File: doc/BRIEF.md
# Store-Wait Load Dependence Predictor

This block learns which loads have, in the past, read memory ahead of an older store that wrote the same location. It holds one flag bit per table slot, and the slot is chosen by a slice of the load's program counter. When a load is fetched, the front end presents its PC and, one cycle later, receives that slot's flag. The flag travels with the instruction into the issue queue. When a load is found to have run ahead of a conflicting store and traps at commit, the commit stage presents the load's PC on the training port and the slot is set.

In the issue queue, a load that carries a set flag is held back while any older store has not yet issued. The queue supplies one summary input saying whether all older stores have issued. The block returns a hold signal in the same cycle. An internal timer wipes the whole table at a fixed interval, so that loads which no longer conflict are not stalled forever.

Top module: `store_wait_predictor`

## Requirements
- R1: While reset is high and in the cycle after it, `lookup_rsp_valid` is 0. After reset every table slot reads as 0.
- R2: A lookup presented with `lookup_valid` high at a clock edge produces `lookup_rsp_valid` high, with the slot's flag on `lookup_rsp_wait`, right after that edge. The response lasts one cycle, and nothing is produced without a lookup.
- R3: The slot index is PC bits [11:2] (10 bits, 1024 slots). PCs that differ only in bits [1:0] or in bits above 11 share a slot. PCs that differ in any of bits [11:2] do not share a slot.
- R4: A training request (`train_valid` high) sets the slot of `train_pc`. Later lookups of that slot return 1.
- R5: A lookup and a training request to the same slot at the same edge return 1 for that lookup. Training one slot leaves every other slot unchanged.
- R6: The whole table is cleared every `CLEAR_INTERVAL` cycles. The first clear falls on the `CLEAR_INTERVAL`-th clock edge after reset is released, and each later clear follows the previous one by `CLEAR_INTERVAL` edges. A slot set before a clear reads 0 after it.
- R7: At a clear edge, a training request at that same edge is dropped, and a lookup at that edge returns 0.
- R8: `iq_hold` is high exactly when `iq_load_valid`, `iq_load_flag` are both high and `iq_older_st_done` is low. It is combinational, within the same cycle.
- R9: Neither lookups nor repeated training of a set slot change it. It stays 1 until the next clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | A load is fetched this cycle |
| lookup_pc | input | PC_W | PC of the fetched load |
| lookup_rsp_valid | output | 1 | Registered: flag response is present |
| lookup_rsp_wait | output | 1 | Registered: predicted store-wait flag |
| train_valid | input | 1 | A load trapped at commit |
| train_pc | input | PC_W | PC of the trapped load |
| iq_load_valid | input | 1 | Issue queue offers a load for issue |
| iq_load_flag | input | 1 | Flag carried with that load |
| iq_older_st_done | input | 1 | All stores older than that load have issued |
| iq_hold | output | 1 | Keep the offered load in the queue |

## Verification
A lookup's flag is due one edge after the lookup is presented. The hold output is due in the same cycle as its inputs. Clears land on edges that the bench counts from the release of reset, with a short interval set for the bench. At each edge, a reference model of the table pushes the expected flag, built from that edge's clear, training and lookup in that order of precedence. The comparison is made at the following falling edge, after the response register has settled. Hold is compared one time step after its inputs change, with no clock edge in between.

// File: rtl/swp_pkg.sv
package swp_pkg;
  // Default geometry of the predictor
  localparam int SWP_PC_W       = 32;
  localparam int SWP_IDX_LSB    = 2;   // 4-byte instructions
  localparam int SWP_IDX_W      = 10;  // 1024 slots
  localparam int SWP_CLEAR_IVL  = 16384;
endpackage

// File: rtl/swp_clear_timer.sv
module swp_clear_timer #(
  parameter int INTERVAL = 16384
) (
  input  logic clk,
  input  logic rst,
  output logic clear_now
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt;

  assign clear_now = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (clear_now) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);

  generate
    if (INTERVAL > 1) begin : g_gap
      assert_clear_gap_R6: assert property (@(posedge clk) disable iff (rst)
        clear_now |=> !clear_now);
    end
  endgenerate
endmodule

// File: rtl/swp_bit_table.sv
module swp_bit_table #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_vld,
  output logic             rd_bit
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] bits;
  logic             hit_same;

  assign hit_same = set_en && (set_idx == rd_idx);

  always_ff @(posedge clk) begin
    if (rst || clr)  bits <= '0;
    else if (set_en) bits[set_idx] <= 1'b1;
  end

  // Read reflects this edge's update: clear first, then training
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      rd_bit <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      rd_bit <= rd_en && !clr && (bits[rd_idx] || hit_same);
    end
  end

  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (bits == '0));

  assert_set_sticks_R4: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clr) |=> bits[$past(set_idx)]);

  assert_clear_read_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && clr) |=> !rd_bit);

  assert_bypass_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && set_en && !clr && (rd_idx == set_idx)) |=> rd_bit);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);
endmodule

// File: rtl/swp_issue_gate.sv
module swp_issue_gate (
  input  logic clk,
  input  logic rst,
  input  logic ld_valid,
  input  logic ld_flag,
  input  logic older_done,
  output logic hold
);
  assign hold = ld_valid && ld_flag && !older_done;

  assert_hold_waits_stores_R8: assert property (@(posedge clk) disable iff (rst)
    hold |-> !older_done);
endmodule

// File: rtl/store_wait_predictor.sv
module store_wait_predictor
  import swp_pkg::*;
#(
  parameter int PC_W           = SWP_PC_W,
  parameter int IDX_LSB        = SWP_IDX_LSB,
  parameter int IDX_W          = SWP_IDX_W,
  parameter int CLEAR_INTERVAL = SWP_CLEAR_IVL
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lookup_valid,
  input  logic [PC_W-1:0] lookup_pc,
  output logic            lookup_rsp_valid,
  output logic            lookup_rsp_wait,
  input  logic            train_valid,
  input  logic [PC_W-1:0] train_pc,
  input  logic            iq_load_valid,
  input  logic            iq_load_flag,
  input  logic            iq_older_st_done,
  output logic            iq_hold
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic             clear_now;
  logic [IDX_W-1:0] rd_idx;
  logic [IDX_W-1:0] wr_idx;

  assign rd_idx = lookup_pc[IDX_MSB:IDX_LSB];
  assign wr_idx = train_pc[IDX_MSB:IDX_LSB];

  // PC bits outside the index slice carry no information here
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lookup_pc, train_pc};

  swp_clear_timer #(.INTERVAL(CLEAR_INTERVAL)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .clear_now (clear_now)
  );

  swp_bit_table #(.IDX_W(IDX_W)) u_table (
    .clk     (clk),
    .rst     (rst),
    .clr     (clear_now),
    .set_en  (train_valid),
    .set_idx (wr_idx),
    .rd_en   (lookup_valid),
    .rd_idx  (rd_idx),
    .rd_vld  (lookup_rsp_valid),
    .rd_bit  (lookup_rsp_wait)
  );

  swp_issue_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .ld_valid   (iq_load_valid),
    .ld_flag    (iq_load_flag),
    .older_done (iq_older_st_done),
    .hold       (iq_hold)
  );

  assert_no_rsp_without_lookup_R2: assert property (@(posedge clk) disable iff (rst)
    !lookup_valid |=> !lookup_rsp_valid);

  assert_rsp_flag_needs_valid_R1: assert property (@(posedge clk) disable iff (rst)
    lookup_rsp_wait |-> lookup_rsp_valid);
endmodule

// File: tb/store_wait_predictor_test.sv
module store_wait_predictor_test;
  localparam int PC_W = 32;
  localparam int IVL  = 200;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst;
  logic lookup_valid, train_valid;
  logic [PC_W-1:0] lookup_pc, train_pc;
  logic lookup_rsp_valid, lookup_rsp_wait;
  logic iq_load_valid, iq_load_flag, iq_older_st_done, iq_hold;

  store_wait_predictor #(.PC_W(PC_W), .CLEAR_INTERVAL(IVL)) uut (
    .clk(clk), .rst(rst),
    .lookup_valid(lookup_valid), .lookup_pc(lookup_pc),
    .lookup_rsp_valid(lookup_rsp_valid), .lookup_rsp_wait(lookup_rsp_wait),
    .train_valid(train_valid), .train_pc(train_pc),
    .iq_load_valid(iq_load_valid), .iq_load_flag(iq_load_flag),
    .iq_older_st_done(iq_older_st_done), .iq_hold(iq_hold)
  );

  typedef struct { logic exp; string tag; } item_t;
  item_t sbq[$];
  logic  model [1024];
  int    k;
  string cur_tag;
  int    checks = 0;
  int    fails  = 0;

  // Reference model: clear beats training; lookup sees this edge's update
  always @(posedge clk) begin
    if (rst) begin
      k = 0;
      foreach (model[i]) model[i] = 1'b0;
    end else begin
      automatic logic clr = ((k % IVL) == IVL - 1);
      automatic int fi = int'(lookup_pc[11:2]);
      automatic int ti = int'(train_pc[11:2]);
      if (lookup_valid) begin
        automatic item_t it;
        it.exp = clr ? 1'b0 : (model[fi] | (train_valid && ti == fi));
        it.tag = cur_tag;
        sbq.push_back(it);
      end
      if (clr) foreach (model[i]) model[i] = 1'b0;
      else if (train_valid) model[ti] = 1'b1;
      k++;
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (lookup_rsp_valid) begin
        checks++;
        if (sbq.size() == 0) begin
          fails++;
          $display("FAIL R2: response without lookup, got valid=1 expected valid=0");
        end else begin
          automatic item_t it = sbq.pop_front();
          if (lookup_rsp_wait !== it.exp) begin
            fails++;
            $display("FAIL %s: lookup_rsp_wait=%0b expected %0b", it.tag, lookup_rsp_wait, it.exp);
          end
        end
      end else if (sbq.size() != 0) begin
        checks++;
        fails++;
        $display("FAIL R2: lookup_rsp_valid=0 expected 1");
        void'(sbq.pop_front());
      end
    end
  end

  task automatic drive(input logic fv, input logic [PC_W-1:0] fpc,
                       input logic tv, input logic [PC_W-1:0] tpc, input string tag);
    lookup_valid = fv; lookup_pc = fpc;
    train_valid  = tv; train_pc  = tpc;
    cur_tag = tag;
    @(negedge clk);
    lookup_valid = 1'b0; train_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic to_clear_slot();
    while ((k % IVL) != IVL - 1) @(negedge clk);
  endtask

  task automatic chk_hold(input logic v, input logic f, input logic d, input string tag);
    iq_load_valid = v; iq_load_flag = f; iq_older_st_done = d;
    #1;
    checks++;
    if (iq_hold !== (v & f & ~d)) begin
      fails++;
      $display("FAIL %s: iq_hold=%0b expected %0b", tag, iq_hold, v & f & ~d);
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [PC_W-1:0] PA = 32'h1000_0040;
  localparam logic [PC_W-1:0] PB = 32'h0000_0800;
  localparam logic [PC_W-1:0] PC_ = 32'h0000_0ABC;
  localparam logic [PC_W-1:0] PD = 32'h0000_0AC0;

  initial begin
    rst = 1'b1;
    lookup_valid = 0; train_valid = 0; lookup_pc = '0; train_pc = '0;
    iq_load_valid = 0; iq_load_flag = 0; iq_older_st_done = 0;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    checks++;
    if (lookup_rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: lookup_rsp_valid=%0b during reset expected 0", lookup_rsp_valid);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (lookup_rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: lookup_rsp_valid=%0b after reset expected 0", lookup_rsp_valid);
    end
    // R1: empty table
    drive(1, PA, 0, '0, "R1");
    drive(1, 32'hFFFF_FFFC, 0, '0, "R1");
    drive(1, 32'h0, 0, '0, "R1");
    // R4: train then read
    drive(0, '0, 1, PA, "R4");
    idle(1);
    drive(1, PA, 0, '0, "R4");
    // R3: aliasing and non-aliasing
    drive(1, PA | 32'h3, 0, '0, "R3");
    drive(1, PA + 32'h1000, 0, '0, "R3");
    drive(1, PA + 32'h4, 0, '0, "R3");
    drive(1, PA ^ 32'h800, 0, '0, "R3");
    // R5: same-edge bypass and isolation
    drive(1, PB, 1, PB, "R5");
    drive(1, PC_, 1, PD, "R5");
    drive(1, PD, 0, '0, "R5");
    drive(1, PC_, 0, '0, "R5");
    // R2: back-to-back and gapped lookups
    drive(1, PB, 0, '0, "R2");
    drive(1, PD, 0, '0, "R2");
    idle(2);
    drive(1, PC_, 0, '0, "R2");
    // R9: retrain and repeated reads
    drive(1, PA, 1, PA, "R9");
    drive(1, PA, 0, '0, "R9");
    drive(1, PA, 0, '0, "R9");
    // R8: hold truth table, flag carried from a lookup
    chk_hold(1, lookup_rsp_wait, 0, "R8");
    chk_hold(1, 1, 1, "R8");
    chk_hold(0, 1, 0, "R8");
    chk_hold(1, 0, 0, "R8");
    chk_hold(1, 1, 0, "R8");
    chk_hold(0, 0, 1, "R8");
    iq_load_valid = 0;
    // R6: pass through a clear, set slots are gone
    to_clear_slot();
    idle(1);
    drive(1, PA, 0, '0, "R6");
    drive(1, PB, 0, '0, "R6");
    drive(1, PD, 0, '0, "R6");
    // R7: training and lookup on the clear edge
    drive(0, '0, 1, PC_, "R7");
    to_clear_slot();
    drive(1, PC_, 1, PD, "R7");
    drive(1, PD, 0, '0, "R7");
    drive(1, PC_, 0, '0, "R7");
    // R6: period of the second-to-third clear
    drive(0, '0, 1, PB, "R6");
    to_clear_slot();
    drive(1, PB, 0, '0, "R6");
    idle(2);
    checks++;
    if (sbq.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing expected 0", sbq.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule